// File: doc/BRIEF.md
# Write-Cycle Status Responder

This block tells a host whether the memory's internal write cycle is still running. A write engine elsewhere supplies a busy flag and the last byte it accepted. The block watches the active-low chip-select, output-enable and write-enable strobes. It reports progress in three ways at once. The first is a polling bit that returns the complement of the top bit of the last byte written. The second is a toggle bit that alternates on every read. The third is a ready/busy line, which is modelled as a drive-enable plus a fixed low level.

A read is any cycle in which chip-select and output-enable are low and write-enable is high. While busy is high, a read returns a status byte and not array data. While busy is low, the array read data passes through unchanged. The read data output is registered, so the value for a read appears one clock after the strobes are sampled. A host may poll any fixed address, because the status byte does not depend on the address.

Top module: `wr_status_resp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dout` is 0, `dout_vld` is 0 and `rdy_oe` is 0.
- R2: When a cycle is a read (ce_n=0, oe_n=0, we_n=1) and busy=1, the next cycle shows `dout[7]` equal to the inverse of `last_byte[7]` from the read cycle.
- R3: Within one busy period, the first read shows `dout[6]`=1, and each later read start shows the opposite of the previous read's value. A read start is a read cycle whose previous cycle was not a read.
- R4: While one read continues across several busy cycles, `dout[6]` keeps the value chosen when that read started.
- R5: During a busy read, bits 5 to 0 of `dout` are 0.
- R6: During a read with busy=0, the next cycle shows `dout` equal to `array_rdata` from the read cycle. No toggling is visible.
- R7: `rdy_oe` equals busy delayed by one clock, and `rdy_lvl` is always 0.
- R8: A new busy period restarts the toggle bit at 1, whatever value the previous period ended on.
- R9: A cycle that is not a read gives `dout`=0 and `dout_vld`=0 one cycle later, and it does not advance the toggle bit.
- R10: If busy rises while a read is already in progress, that cycle counts as a read start, so it shows 1. The next read start then shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal write cycle in progress |
| last_byte | input | DW | Last byte accepted by the write engine |
| array_rdata | input | DW | Array read data for the current address |
| dout | output | DW | Registered read data or status byte |
| dout_vld | output | 1 | A read was sampled in the previous cycle |
| rdy_oe | output | 1 | Ready/busy drive enable (1 = pull low) |
| rdy_lvl | output | 1 | Level driven on ready/busy when enabled |

## Verification
Two events can land on the same clock edge. In the first, busy rises while a read is held open. In the second, busy falls on the very cycle a new read starts. The bench creates both by changing busy on the same edge as the strobes, and by changing busy in the middle of a held read. A behavioural reference model counts reads per busy period, and the DUT is compared with it on every clock. In the rising case, the toggle value that follows must be 1 and then 0. In the falling case, the byte returned must be array data with no status bits.

// File: rtl/wr_status_resp.sv
module wr_status_resp #(
  parameter int DW       = 8,
  parameter int POLL_BIT = DW - 1,
  parameter int TOG_BIT  = DW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          busy,
  input  logic [DW-1:0] last_byte,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          rdy_oe,
  output logic          rdy_lvl
);

  localparam logic [DW-1:0] STAT_MASK = (DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT);

  logic          rd, rd_q, busy_q, tog, rd_new, tog_bit;
  logic [DW-1:0] status, nxt_dout;

  assign rd      = ~ce_n & ~oe_n & we_n;
  assign rd_new  = rd & (~rd_q | (busy & ~busy_q));
  assign tog_bit = rd_new ? tog : ~tog;

  always_comb begin
    status           = '0;
    status[POLL_BIT] = ~last_byte[POLL_BIT];
    status[TOG_BIT]  = tog_bit;
  end

  assign nxt_dout = !rd ? '0 : (busy ? status : array_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      busy_q   <= 1'b0;
      tog      <= 1'b1;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      rd_q     <= rd;
      busy_q   <= busy;
      dout     <= nxt_dout;
      dout_vld <= rd;
      if (!busy)       tog <= 1'b1;
      else if (rd_new) tog <= ~tog;
    end
  end

  assign rdy_oe  = busy_q;
  assign rdy_lvl = 1'b0;

  // R7
  busy_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rdy_oe);
  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !rdy_oe);
  // R2
  poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> (dout[POLL_BIT] == ~$past(last_byte[POLL_BIT])));
  // R5
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> ((dout & ~STAT_MASK) == '0));
  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !busy) |=> (dout == $past(array_rdata)));
  // R9
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (!dout_vld && dout == '0));
  // R4
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy && rd_q && busy_q) |=> $stable(dout[TOG_BIT]));

endmodule

// File: tb/wr_status_resp_tb.sv
module wr_status_resp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0] last_byte = 8'h00, array_rdata = 8'h00;
  logic [7:0] dout;
  logic       dout_vld, rdy_oe, rdy_lvl;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  wr_status_resp u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .last_byte(last_byte), .array_rdata(array_rdata),
    .dout(dout), .dout_vld(dout_vld), .rdy_oe(rdy_oe), .rdy_lvl(rdy_lvl));

  // reference model state
  logic [7:0] exp_dout = 8'h00;
  logic       exp_vld = 1'b0, exp_oe = 1'b0, exp_rst = 1'b1, exp_busyrd = 1'b0, exp_idlerd = 1'b0;
  bit         prev_rd = 0, prev_busy = 0, shown = 1, had_period = 0, started = 0;
  int         reads = 0;
  string      tog_tag = "R3";

  always @(posedge clk) begin
    bit rdm, first;
    started = 1;
    if (!rst_n) begin
      exp_dout = 0; exp_vld = 0; exp_oe = 0; exp_rst = 1;
      exp_busyrd = 0; exp_idlerd = 0;
      prev_rd = 0; prev_busy = 0; reads = 0; had_period = 0;
    end else begin
      rdm   = !ce_n && !oe_n && we_n;
      first = rdm && (!prev_rd || (busy && !prev_busy));
      exp_rst = 0; exp_oe = busy; exp_vld = rdm;
      exp_busyrd = rdm && busy; exp_idlerd = rdm && !busy;
      if (!rdm) exp_dout = 0;
      else if (!busy) exp_dout = array_rdata;
      else begin
        if (first) begin
          shown = (reads % 2 == 0);
          if (prev_rd && !prev_busy) tog_tag = "R10";
          else if (reads == 0 && had_period) tog_tag = "R8";
          else tog_tag = "R3";
          reads++;
        end else tog_tag = "R4";
        exp_dout = 0;
        exp_dout[7] = ~last_byte[7];
        exp_dout[6] = shown;
      end
      if (busy) had_period = 1;
      if (!busy) reads = 0;
      prev_rd = rdm; prev_busy = busy;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (exp_rst) begin
        check("R1", {dout_vld, rdy_oe, dout[5:0]}, 8'h00);
        check("R1", {6'b0, dout[7:6]}, 8'h00);
      end else begin
        check("R7", {6'b0, rdy_oe, rdy_lvl}, {6'b0, exp_oe, 1'b0});
        if (exp_busyrd) begin
          check("R2", {7'b0, dout[7]}, {7'b0, exp_dout[7]});
          check(tog_tag, {7'b0, dout[6]}, {7'b0, exp_dout[6]});
          check("R5", {2'b0, dout[5:0]}, 8'h00);
        end else if (exp_idlerd) begin
          check("R6", dout, exp_dout);
        end else begin
          check("R9", {dout_vld, dout[6:0]}, 8'h00);
          check("R9", {7'b0, dout[7]}, 8'h00);
        end
        if (exp_vld) check("R9", {7'b0, dout_vld}, 8'h01);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd_on();  ce_n = 0; oe_n = 0; we_n = 1; endtask
  task automatic rd_off(); ce_n = 1; oe_n = 1; we_n = 1; endtask

  task automatic do_read(input int len);
    rd_on(); step(len);
    rd_off(); step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1; step(1);                                // R1 first cycle after reset
    // R6 idle reads, several data patterns
    array_rdata = 8'h5A; do_read(2);
    array_rdata = 8'hFF; do_read(1);
    array_rdata = 8'h81; rd_on(); step(1); array_rdata = 8'h7E; step(1); rd_off(); step(1);
    // R9 non-read strobe combinations
    ce_n = 0; oe_n = 1; we_n = 1; step(2);
    ce_n = 0; oe_n = 0; we_n = 0; step(2);
    ce_n = 1; oe_n = 0; we_n = 1; step(2);
    rd_off();
    // R2 R3 R4 R5 R7 busy period A, polling bit 7 of 0xA5 -> 0
    last_byte = 8'hA5; busy = 1; step(2);
    do_read(3); do_read(1); do_read(2);
    ce_n = 0; oe_n = 0; we_n = 0; step(2); rd_off(); step(1);  // R9 no advance
    do_read(2); do_read(1);
    busy = 0; step(2);                                 // R7 release
    array_rdata = 8'hC3; do_read(2);
    // R8 period B after odd read count, last_byte bit7 = 0
    last_byte = 8'h3C; busy = 1; step(1);
    do_read(1); do_read(2); do_read(1);
    busy = 0; step(1);
    // R10 busy rises during an open read
    array_rdata = 8'h11; rd_on(); step(2);
    busy = 1; last_byte = 8'h80; step(3);
    rd_off(); step(1);
    do_read(2); do_read(1);
    // busy falls on the same edge a new read starts
    rd_on(); busy = 0; array_rdata = 8'h99; step(2); rd_off(); step(1);
    // busy rises on the same edge a new read starts
    rd_on(); busy = 1; last_byte = 8'h01; step(2); rd_off(); step(1);
    do_read(1);
    busy = 0; step(2);
    // reset in mid-busy then R1
    busy = 1; step(2); rst_n = 0; step(2); rst_n = 1; busy = 0; step(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule